// File: doc/BRIEF.md
# Pilot Block Position Indicator

This block follows the symbol stream of a receiver that is already frame-aligned. It marks the symbols that belong to pilot blocks inside the payload. Each time a frame header finishes, the frame synchronizer gives one pulse, along with a flag that says whether the new frame carries pilots. From then on the block counts the valid payload symbols. After each run of 1440 data symbols (16 slots of 90) it raises a pilot strobe for the next 36 valid symbols. It then starts counting data again.

The block has no frame-length table. A frame lasts until the next header-end pulse. That pulse clears all counting state and cancels any pilot block that is pending or in progress, because the new header occupies that position. A small index reports how many pilot blocks of the current frame have completed. Downstream phase estimators can use it to tell the blocks apart.

Top module: `pilot_pos_ind`

## Requirements
- R1: When reset is released, pilot_valid is 0, pilot_idx is 0, and no frame is active.
- R2: The symbol that arrives in the hdr_end cycle is not counted. The first valid symbol after hdr_end is payload symbol 0.
- R3: In a frame whose pilots_on was 1 at its hdr_end, payload symbols 0 to 1439 have pilot_valid low. Symbol 1440 is the first pilot symbol.
- R4: pilot_valid is high for exactly 36 valid symbols per pilot block.
- R5: Cycles with sym_valid low do not advance any count, and pilot_valid is 0 in those cycles.
- R6: After each pilot block, the data count restarts at zero. The period of 1440 data symbols plus 36 pilot symbols repeats until the frame ends.
- R7: In a frame whose pilots_on was 0 at its hdr_end, pilot_valid never rises.
- R8: A hdr_end ends the current frame. pilot_valid is 0 in that cycle, any pending or running pilot block is dropped, and counting restarts under the new flag.
- R9: pilot_idx is 0 at the start of a frame. It goes up by one when the last symbol of each pilot block is accepted and holds at its all-ones value.
- R10: Before the first hdr_end after reset, pilot_valid stays 0 whatever sym_valid and pilots_on do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| hdr_end | input | 1 | Single-cycle pulse: the header of a new frame ends this cycle |
| pilots_on | input | 1 | Pilot flag of the new frame, sampled when hdr_end is high |
| pilot_valid | output | 1 | The current symbol belongs to a pilot block |
| pilot_idx | output | IDX_W | Number of completed pilot blocks in the current frame (saturating) |

## Verification
The assertions check on every cycle the rules that are local in time. pilot_valid only occurs with sym_valid, only in pilot-active frames and never before a header (R5, R7, R10). The count holds while there is no symbol. A pilot block is entered only from a completed data run. The index only steps by one, clears, or holds, and it reads zero after each header (R3, R8, R9). The exact positions of 1440 and 36, the repetition across several blocks, saturation of the index, and the cancellation of a pilot block partway through are visible only in the bench's scenarios. The bench compares every symbol against a period computed in closed form.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_PILOT = 2'd2
  } phase_e;

  // next value of a modulo-lim counter
  function automatic int unsigned wrap_inc(input int unsigned c, input int unsigned lim);
    return (c + 1 >= lim) ? 0 : c + 1;
  endfunction

  // saturating increment bounded by maxv
  function automatic int unsigned sat_inc(input int unsigned c, input int unsigned maxv);
    return (c >= maxv) ? maxv : c + 1;
  endfunction

endpackage

// File: rtl/pbi_sym_counter.sv
module pbi_sym_counter #(
  parameter int unsigned DATA_LEN  = 1440,
  parameter int unsigned PILOT_LEN = 36,
  parameter int unsigned CW        = $clog2(DATA_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          sel_pilot,
  output logic [CW-1:0] cnt,
  output logic          seg_last
);
  import pbi_pkg::*;

  logic [CW-1:0] lim_m1;
  assign lim_m1   = sel_pilot ? CW'(PILOT_LEN - 1) : CW'(DATA_LEN - 1);
  assign seg_last = en && (cnt == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= CW'(wrap_inc(32'(cnt), 32'(lim_m1) + 1));
  end

  // R5: the count holds when no symbol is accepted
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt));

  // R6: the count never leaves the data range
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DATA_LEN));

endmodule

// File: rtl/pbi_phase_ctrl.sv
module pbi_phase_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hdr_end,
  input  logic            pilots_on,
  input  logic            sym_valid,
  input  logic            seg_last,
  output pbi_pkg::phase_e phase,
  output logic            frame_pilots,
  output logic            cnt_en,
  output logic            cnt_clr,
  output logic            blk_done
);
  import pbi_pkg::*;

  assign cnt_clr  = hdr_end;
  assign cnt_en   = sym_valid && !hdr_end && (phase != PH_IDLE);
  assign blk_done = seg_last && (phase == PH_PILOT) && !hdr_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      frame_pilots <= 1'b0;
    end else if (hdr_end) begin
      phase        <= PH_DATA;
      frame_pilots <= pilots_on;
    end else if (seg_last) begin
      if (phase == PH_PILOT)                    phase <= PH_DATA;
      else if (phase == PH_DATA && frame_pilots) phase <= PH_PILOT;
    end
  end

  // R3: a pilot block is entered only from a completed data run
  p_pilot_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PILOT && $past(phase) != PH_PILOT) |-> $past(seg_last));

  // R7: pilot phase only in a pilot-active frame
  p_pilot_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PILOT) |-> frame_pilots);

endmodule

// File: rtl/pbi_blk_index.sv
module pbi_blk_index #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] idx
);
  import pbi_pkg::*;

  localparam int unsigned IDX_MAX = (1 << IDX_W) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= IDX_W'(sat_inc(32'(idx), IDX_MAX));
  end

  // R9: the index steps by one, clears, or holds
  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> (idx == '0 || idx == $past(idx) + 1'b1));

endmodule

// File: rtl/pilot_pos_ind.sv
module pilot_pos_ind #(
  parameter int unsigned DATA_LEN  = 1440,
  parameter int unsigned PILOT_LEN = 36,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             hdr_end,
  input  logic             pilots_on,
  output logic             pilot_valid,
  output logic [IDX_W-1:0] pilot_idx
);
  import pbi_pkg::*;

  localparam int unsigned CW = $clog2(DATA_LEN);

  phase_e        phase;
  logic          frame_pilots;
  logic          cnt_en;
  logic          cnt_clr;
  logic          blk_done;
  logic          seg_last;
  logic [CW-1:0] sym_cnt;

  pbi_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hdr_end(hdr_end), .pilots_on(pilots_on),
    .sym_valid(sym_valid), .seg_last(seg_last), .phase(phase),
    .frame_pilots(frame_pilots), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .blk_done(blk_done)
  );

  pbi_sym_counter #(.DATA_LEN(DATA_LEN), .PILOT_LEN(PILOT_LEN), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .sel_pilot(phase == PH_PILOT), .cnt(sym_cnt), .seg_last(seg_last)
  );

  pbi_blk_index #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(blk_done), .idx(pilot_idx)
  );

  assign pilot_valid = (phase == PH_PILOT) && sym_valid && !hdr_end;

  // R5: a pilot strobe always coincides with a symbol
  p_pv_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pilot_valid |-> sym_valid);

  // R8: the index reads zero after each header
  p_hdr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_end |=> (pilot_idx == '0));

  // R10: nothing is flagged before a frame is active
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !pilot_valid);

endmodule

// File: tb/pilot_pos_ind_tb_top.sv
module pilot_pos_ind_tb_top;

  localparam int DLEN  = 1440;
  localparam int PLEN  = 36;
  localparam int PER   = DLEN + PLEN;
  localparam int IW    = 2;
  localparam int IMAX  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic hdr_end = 1'b0;
  logic pilots_on = 1'b0;
  logic pilot_valid;
  logic [IW-1:0] pilot_idx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pilot_pos_ind #(.DATA_LEN(DLEN), .PILOT_LEN(PLEN), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .hdr_end(hdr_end),
    .pilots_on(pilots_on), .pilot_valid(pilot_valid), .pilot_idx(pilot_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge and sample mid-cycle
  task automatic step(input logic v, input logic h, input logic f);
    @(negedge clk);
    sym_valid = v; hdr_end = h; pilots_on = f;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 pilot_valid", pilot_valid, 0);
    check("R1 pilot_idx", pilot_idx, 0);
    rst_n = 1'b1;
  endtask

  // R10: symbols with no header never raise the strobe
  task automatic t_no_header(input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b0, 1'b1);
      if (pilot_valid !== 1'b0 || pilot_idx !== '0) bad++;
    end
    check("R10 strobes before header", bad, 0);
  endtask

  // one frame: a header cycle, then n payload symbols, with an idle cycle
  // inserted every stall symbols (0 = none)
  task automatic t_frame(input bit pil, input int n, input int stall);
    int exp_idx;
    bit exp_pv;
    string req;
    step(1'b1, 1'b1, pil);
    check("R8 header cycle strobe", pilot_valid, 0);
    for (int k = 0; k < n; k++) begin
      exp_idx = pil ? (k / PER) : 0;
      if (exp_idx > IMAX) exp_idx = IMAX;
      if (stall != 0 && k % stall == stall - 1) begin
        step(1'b0, 1'b0, ~pil);
        check("R5 idle strobe", pilot_valid, 0);
        check("R5 idle index", pilot_idx, exp_idx);
      end
      step(1'b1, 1'b0, ~pil);
      exp_pv = pil && ((k % PER) >= DLEN);
      if (k == 0) req = "R2";
      else if (!pil) req = "R7";
      else if (k >= PER) req = "R6";
      else if (exp_pv) req = "R4";
      else req = "R3";
      check(req, pilot_valid, exp_pv);
      check("R9 index", pilot_idx, exp_idx);
    end
  endtask

  initial begin
    t_reset();
    t_no_header(1500);                   // R10
    t_frame(1'b1, 2 * PER + 200, 7);     // R3 R4 R5 R6 R9 with stalls
    t_frame(1'b1, DLEN + 10, 0);         // R8: cut inside a pilot block
    t_frame(1'b1, DLEN, 0);              // R8: cut where a pilot block is due
    t_frame(1'b0, 2 * PER, 0);           // R7
    t_frame(1'b1, 5 * PER + 5, 0);       // R9 saturation, R8 restart after R7 frame
    step(1'b1, 1'b1, 1'b0);
    check("R8 header drops strobe", pilot_valid, 0);
    step(1'b1, 1'b0, 1'b0);
    check("R8 index cleared", pilot_idx, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule